// File: doc/BRIEF.md
# Frequency-Locked Loop Integrator

This block is the digital core of a frequency-locked loop. It runs on the clock of a digitally controlled oscillator and keeps that oscillator locked to a slow reference clock. The oscillator clock is divided first by a selectable prescale factor D and then by a programmable count of N+1. The reference is brought into the oscillator clock domain, and each of its rising edges is counted. A 10-bit saturating up/down integrator rises by one for each reference edge and falls by one for each divided oscillator period. When the two rates match, the integrator holds steady on average.

The integrator value feeds back to the oscillator as two fields. The upper five bits choose a coarse tap, and codes 28 to 31 all act as the same top tap. The lower five bits form a fractional value. Within every 32 cycles, the modulator applies the next higher tap for that many cycles, so the average frequency falls between two adjacent taps. A control input turns the fractional mixing off. The full integrator value is always available for readback.

Top module: `fll_integrator_core`

## Requirements
- R1: After reset the integrator reads 512, the tap code is 16, the fraction is 0 and the applied tap is 16.
- R2: With the reference idle, the integrator falls by exactly one every D*(N+1) clock cycles. The D field encodes 00 as 1, 01 as 2, 10 as 4 and 11 as 8, and N is the 7-bit multiplier input.
- R3: Each rising edge of the reference input raises the integrator by exactly one. The edge is taken through a two-stage synchroniser and an edge detector, so it arrives a few cycles after the edge.
- R4: When a reference edge and a divided-period event fall in the same cycle, the integrator keeps its value.
- R5: The integrator saturates at 1023 and never wraps to 0.
- R6: The integrator saturates at 0 and never wraps to 1023.
- R7: The tap code is integrator bits 9:5, with codes 28 to 31 all reported as 28. The fraction output is integrator bits 4:0.
- R8: With mixing enabled and tap code below 28, any 32 consecutive cycles of steady integrator value show the applied tap equal to tap code + 1 in exactly fraction cycles and equal to the tap code in the rest. At tap code 28 the applied tap is always 28.
- R9: With the mixing-disable input at 1, the applied tap always equals the tap code.
- R10: The readback output always shows the current integrator value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk_in | input | 1 | Reference clock, asynchronous to clk |
| div_sel | input | 2 | Prescale select: D = 1, 2, 4 or 8 |
| mult_n | input | 7 | Multiplier; second stage divides by N+1 |
| mix_off | input | 1 | 1 disables fractional tap mixing |
| integ_value | output | 10 | Integrator readback |
| tap_code | output | 5 | Folded coarse tap (0 to 28) |
| frac_code | output | 5 | Fractional mixing value |
| dco_tap | output | 5 | Tap applied to the oscillator this cycle |

## Verification
The integrator's up event, which comes from a synchronised reference edge, and its down event, which comes from the divider wrapping, can land in the same cycle. To force this overlap, the divider is set to D=1 and N=0, so a down event occurs in every cycle, and reference pulses are then driven into it. Each reference edge must then produce exactly one cycle in which the value does not change, with every other cycle stepping down by one. The bench counts the unchanged cycles and the downward steps and compares them with the number of pulses it drove.

// File: rtl/fll_pkg.sv
package fll_pkg;
    localparam int unsigned INTEG_W   = 10;
    localparam int unsigned TAP_W     = 5;
    localparam int unsigned MULT_W    = 7;
    localparam int unsigned DSEL_W    = 2;
    localparam int unsigned TAP_LAST  = 28;

    function automatic int unsigned prescale_factor(input int unsigned sel);
        return 32'd1 << sel;
    endfunction
endpackage

// File: rtl/fll_refsync.sv
module fll_refsync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_async,
    output logic rise_evt
);
    localparam int unsigned SH_W = STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[SH_W-2:0], ref_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_evt = st_q.sh[SH_W-2] & ~st_q.sh[SH_W-1];
endmodule

// File: rtl/fll_fbdiv.sv
module fll_fbdiv #(
    parameter int unsigned MULT_W = 7,
    parameter int unsigned DSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DSEL_W-1:0] div_sel,
    input  logic [MULT_W-1:0] mult_n,
    output logic              fall_evt
);
    localparam int unsigned PRE_W = (1 << DSEL_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [MULT_W-1:0] cnt;
        logic              evt;
    } div_t;

    div_t st_d, st_q;
    logic [PRE_W-1:0] pre_lim;
    logic             pre_wrap;

    always_comb begin
        pre_lim  = PRE_W'(fll_pkg::prescale_factor(32'(div_sel)) - 32'd1);
        pre_wrap = (st_q.pre >= pre_lim);
        st_d     = st_q;
        st_d.evt = 1'b0;
        if (pre_wrap) begin
            st_d.pre = '0;
            if (st_q.cnt >= mult_n) begin
                st_d.cnt = '0;
                st_d.evt = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fall_evt = st_q.evt;
endmodule

// File: rtl/fll_accum.sv
module fll_accum #(
    parameter int unsigned W    = 10,
    parameter int unsigned INIT = 512
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = '1;

    typedef struct packed {
        logic [W-1:0] val;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case ({inc, dec})
            2'b10: if (st_q.val != TOP) st_d.val = st_q.val + 1'b1;
            2'b01: if (st_q.val != '0)  st_d.val = st_q.val - 1'b1;
            default: st_d.val = st_q.val;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.val <= W'(INIT);
        else        st_q     <= st_d;
    end

    assign value = st_q.val;
endmodule

// File: rtl/fll_mixer.sv
module fll_mixer #(
    parameter int unsigned W        = 10,
    parameter int unsigned TAP_W    = 5,
    parameter int unsigned TAP_LAST = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     value,
    input  logic             mix_off,
    output logic [TAP_W-1:0] tap_code,
    output logic [TAP_W-1:0] frac_code,
    output logic [TAP_W-1:0] dco_tap
);
    localparam int unsigned FR_W = W - TAP_W;
    localparam logic [TAP_W-1:0] LAST = TAP_W'(TAP_LAST);

    typedef struct packed {
        logic [FR_W-1:0] phase;
    } mix_t;

    mix_t st_d, st_q;
    logic [TAP_W-1:0] raw_tap;
    logic [FR_W-1:0]  frac;
    logic [TAP_W-1:0] base;
    logic             use_next;

    always_comb begin
        st_d       = st_q;
        st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        raw_tap  = value[W-1 -: TAP_W];
        frac     = value[FR_W-1:0];
        base     = (raw_tap > LAST) ? LAST : raw_tap;
        use_next = !mix_off && (frac > st_q.phase) && (base < LAST);
        dco_tap  = use_next ? base + 1'b1 : base;
    end

    assign tap_code  = base;
    assign frac_code = TAP_W'(frac);
endmodule

// File: rtl/fll_integrator_core.sv
module fll_integrator_core #(
    parameter int unsigned INTEG_W     = fll_pkg::INTEG_W,
    parameter int unsigned TAP_W       = fll_pkg::TAP_W,
    parameter int unsigned MULT_W      = fll_pkg::MULT_W,
    parameter int unsigned DSEL_W      = fll_pkg::DSEL_W,
    parameter int unsigned TAP_LAST    = fll_pkg::TAP_LAST,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_clk_in,
    input  logic [DSEL_W-1:0]  div_sel,
    input  logic [MULT_W-1:0]  mult_n,
    input  logic               mix_off,
    output logic [INTEG_W-1:0] integ_value,
    output logic [TAP_W-1:0]   tap_code,
    output logic [TAP_W-1:0]   frac_code,
    output logic [TAP_W-1:0]   dco_tap
);
    localparam int unsigned MID = 1 << (INTEG_W - 1);

    logic up_evt;
    logic down_evt;

    fll_refsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_async(ref_clk_in),
        .rise_evt (up_evt)
    );

    fll_fbdiv #(.MULT_W(MULT_W), .DSEL_W(DSEL_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .mult_n  (mult_n),
        .fall_evt(down_evt)
    );

    fll_accum #(.W(INTEG_W), .INIT(MID)) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (up_evt),
        .dec  (down_evt),
        .value(integ_value)
    );

    fll_mixer #(.W(INTEG_W), .TAP_W(TAP_W), .TAP_LAST(TAP_LAST)) u_mix (
        .clk      (clk),
        .rst_n    (rst_n),
        .value    (integ_value),
        .mix_off  (mix_off),
        .tap_code (tap_code),
        .frac_code(frac_code),
        .dco_tap  (dco_tap)
    );
endmodule

// File: rtl/fll_integrator_checker.sv
module fll_integrator_checker #(
    parameter int unsigned INTEG_W  = 10,
    parameter int unsigned TAP_W    = 5,
    parameter int unsigned TAP_LAST = 28
) (
    input logic               clk,
    input logic               rst_n,
    input logic               up_evt,
    input logic               down_evt,
    input logic               mix_off,
    input logic [INTEG_W-1:0] integ_value,
    input logic [TAP_W-1:0]   tap_code,
    input logic [TAP_W-1:0]   dco_tap
);
    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(integ_value) == 32'($past(integ_value))) ||
        (32'(integ_value) == 32'($past(integ_value)) + 1) ||
        (32'(integ_value) + 1 == 32'($past(integ_value))));

    assert_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_evt && down_evt) |=> $stable(integ_value));

    assert_up_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        up_evt |=> !up_evt);

    assert_fold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tap_code) <= TAP_LAST);

    assert_mix_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dco_tap == tap_code) ||
        ((32'(dco_tap) == 32'(tap_code) + 1) && (32'(tap_code) < TAP_LAST)));

    assert_mix_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mix_off |-> (dco_tap == tap_code));
endmodule

bind fll_integrator_core fll_integrator_checker #(
    .INTEG_W(INTEG_W), .TAP_W(TAP_W), .TAP_LAST(TAP_LAST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_evt     (up_evt),
    .down_evt   (down_evt),
    .mix_off    (mix_off),
    .integ_value(integ_value),
    .tap_code   (tap_code),
    .dco_tap    (dco_tap)
);

// File: tb/fll_integrator_core_test.sv
module fll_integrator_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_clk_in = 1'b0;
    logic [1:0] div_sel = 2'd3;
    logic [6:0] mult_n = 7'd127;
    logic       mix_off = 1'b0;
    logic [9:0] integ_value;
    logic [4:0] tap_code, frac_code, dco_tap;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // monitor state
    int  prev_val = -1;
    int  wraps = 0;
    int  map_err = 0;
    bit  win_on = 1'b0;
    int  win_zero = 0, win_minus = 0, win_other = 0;

    always #4 clk = ~clk;

    fll_integrator_core uut (
        .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in),
        .div_sel(div_sel), .mult_n(mult_n), .mix_off(mix_off),
        .integ_value(integ_value), .tap_code(tap_code),
        .frac_code(frac_code), .dco_tap(dco_tap)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R7/R10 mapping and R5/R6 wrap monitor, sampled away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            int v, et;
            v  = int'(integ_value);
            et = (v >> 5) > 28 ? 28 : (v >> 5);
            if (int'(tap_code) != et || int'(frac_code) != (v & 31)) map_err++;
            if (prev_val >= 0) begin
                if ((prev_val > 1000 && v < 24) || (prev_val < 24 && v > 1000)) wraps++;
                if (win_on) begin
                    if (v == prev_val)          win_zero++;
                    else if (v == prev_val - 1) win_minus++;
                    else                        win_other++;
                end
            end
            prev_val = v;
        end else begin
            prev_val = -1;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic ref_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ref_clk_in = 1'b1;
            repeat (3) @(negedge clk);
            ref_clk_in = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic mix_window(output int n_next, output int n_other);
        int base;
        n_next = 0; n_other = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            base = int'(tap_code);
            if (int'(dco_tap) == base + 1) n_next++;
            else if (int'(dco_tap) != base) n_other++;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int nn, no, last, cyc, idx;
        int nvals[4];
        int stamps[4];
        nvals = '{0, 1, 3, 6};

        // R1 reset state
        div_sel = 2'd3; mult_n = 7'd127; mix_off = 1'b0;
        do_reset();
        @(negedge clk);
        chk(integ_value == 10'd512, "R1 integ", int'(integ_value), 512);
        chk(tap_code == 5'd16, "R1 tap", int'(tap_code), 16);
        chk(frac_code == 5'd0, "R1 frac", int'(frac_code), 0);
        chk(dco_tap == 5'd16, "R1 dco_tap", int'(dco_tap), 16);
        mix_window(nn, no);
        chk(nn == 0 && no == 0, "R8 frac0 mix", nn, 0);

        // R3 reference edges raise the count
        ref_pulses(20);
        repeat (6) @(negedge clk);
        chk(integ_value == 10'd532, "R3 up count", int'(integ_value), 532);
        chk(frac_code == 5'd20, "R10 frac readback", int'(frac_code), 20);
        mix_window(nn, no);
        chk(nn == 20 && no == 0, "R8 mix frac20", nn, 20);
        ref_pulses(11);
        repeat (6) @(negedge clk);
        chk(integ_value == 10'd543, "R3 up count 2", int'(integ_value), 543);
        mix_window(nn, no);
        chk(nn == 31 && no == 0, "R8 mix frac31", nn, 31);
        mix_off = 1'b1;
        mix_window(nn, no);
        chk(nn == 0 && no == 0, "R9 mix off", nn, 0);
        mix_off = 1'b0;

        // R2 divider sweep: all D codes, several N
        for (int ds = 0; ds < 4; ds++) begin
            for (int ni = 0; ni < 4; ni++) begin
                div_sel = 2'(ds); mult_n = 7'(nvals[ni]);
                do_reset();
                last = int'(integ_value);
                idx = 0; cyc = 0;
                while (idx < 4 && cyc < 1000) begin
                    @(negedge clk);
                    cyc++;
                    if (int'(integ_value) != last) begin
                        stamps[idx] = cyc;
                        idx++;
                        last = int'(integ_value);
                    end
                end
                for (int k = 1; k < 4; k++) begin
                    chk(idx == 4 && stamps[k] - stamps[k-1] == (1 << ds) * (nvals[ni] + 1),
                        "R2 period", stamps[k] - stamps[k-1], (1 << ds) * (nvals[ni] + 1));
                end
            end
        end

        // R4 up and down in the same cycle cancel
        div_sel = 2'd0; mult_n = 7'd0;
        do_reset();
        repeat (20) @(negedge clk);
        win_zero = 0; win_minus = 0; win_other = 0;
        win_on = 1'b1;
        ref_pulses(10);
        repeat (40) @(negedge clk);
        win_on = 1'b0;
        chk(win_zero == 10, "R4 cancelled cycles", win_zero, 10);
        chk(win_other == 0, "R4 other steps", win_other, 0);
        chk(win_minus == 90, "R4 down steps", win_minus, 90);

        // R6 saturate at zero
        repeat (600) @(negedge clk);
        chk(integ_value == 10'd0, "R6 floor", int'(integ_value), 0);
        repeat (50) @(negedge clk);
        chk(integ_value == 10'd0, "R6 floor held", int'(integ_value), 0);

        // R5 saturate at top, R7/R8 tap folding
        div_sel = 2'd3; mult_n = 7'd127;
        do_reset();
        ref_pulses(600);
        chk(integ_value >= 10'd1022, "R5 near top", int'(integ_value), 1023);
        chk(tap_code == 5'd28, "R7 fold tap", int'(tap_code), 28);
        mix_window(nn, no);
        chk(nn == 0 && no == 0 && dco_tap == 5'd28, "R8 top tap fixed", int'(dco_tap), 28);
        ref_pulses(3);
        repeat (6) @(negedge clk);
        chk(integ_value == 10'd1023, "R5 ceiling", int'(integ_value), 1023);

        chk(wraps == 0, "R5 R6 no wrap", wraps, 0);
        chk(map_err == 0, "R7 tap/frac mapping", map_err, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule